// File: doc/BRIEF.md
# Interrupt Pending and Priority Tracker

This block records which interrupt vectors are waiting, which are being serviced, and which were raised as level-triggered requests. The vector space is 256 entries wide and is kept as three bitmaps. Fixed and lowest-priority deliveries arrive on an accept port. The block combines a task priority value with the class of the highest vector in service to form a processor priority. It offers the highest waiting vector to the core only when that vector's class beats the processor priority.

The core takes an offered vector through an acknowledge strobe, which moves it into service. An end-of-interrupt strobe retires the highest vector in service. When that vector was level-triggered, a one-cycle broadcast carries its number out, so that an upstream interrupt router can re-arm its line.

Top module: `irq_prio_tracker`

## Requirements
- R1: After reset, all three bitmaps and the task priority are zero, so `ppr` reads 0. `pend_valid`, `acc_ok` and `eoi_bc_valid` are low.
- R2: An enabled accept of vector V sets V's pending bit and records its trigger mode (1 = level when `acc_level`=1, 0 = edge). When the pending bit was clear beforehand, `acc_ok` pulses high in the cycle after the accept.
- R3: An accept of a vector whose pending bit is already set does not raise `acc_ok`. A level-triggered duplicate leaves the trigger-mode bit as it was. An edge-triggered duplicate clears that bit.
- R4: An accept has no effect unless both `hw_en` and `sw_en` are 1.
- R5: An accept of a vector below 16 has no effect. The block never reports a vector below 16.
- R6: `pend_vector` is the highest-numbered pending vector. `pend_valid` is 1 only if one is pending and its class (bits 7:4) is strictly greater than `ppr[7:4]`.
- R7: `ppr` equals the task priority when its bits 7:4 are greater than or equal to the class of the highest in-service vector (0 when none is in service). Otherwise `ppr` is that vector with bits 3:0 cleared.
- R8: A task priority write with `tpr_we` is reflected in `ppr` in the cycle after the write.
- R9: `ack_valid` while `pend_valid` is 1 clears the offered vector's pending bit and sets its in-service bit. While `pend_valid` is 0, `ack_valid` has no effect.
- R10: `eoi_strobe` clears only the highest in-service bit and updates `ppr` in the next cycle. With nothing in service it has no effect.
- R11: When the vector retired by an EOI has its trigger-mode bit set, that bit is cleared. In the next cycle, `eoi_bc_valid` is high for exactly one cycle with `eoi_bc_vector` equal to the retired vector. Edge-triggered vectors produce no broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Hardware enable for accepts |
| sw_en | input | 1 | Software enable for accepts |
| acc_valid | input | 1 | Accept request strobe |
| acc_vector | input | 8 | Vector being delivered |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| acc_ok | output | 1 | Accept added a new pending vector (one cycle late) |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| ack_valid | input | 1 | Core takes the offered vector |
| eoi_strobe | input | 1 | End of interrupt |
| pend_valid | output | 1 | Offered vector may be delivered |
| pend_vector | output | 8 | Highest pending vector |
| ppr | output | 8 | Processor priority |
| eoi_bc_valid | output | 1 | Level-triggered EOI broadcast pulse |
| eoi_bc_vector | output | 8 | Vector retired by the broadcast EOI |

## Verification
The trigger-mode bitmap has no port of its own and can only be seen through the broadcast that an EOI produces. The hardest cases are therefore the duplicate-request rules: a level duplicate must keep the level mark, and an edge duplicate must erase it. The stimulus reaches them by queuing a level request for a vector and then repeating it at the same vector as either level or edge. It then acknowledges the vector and retires it, and the presence or absence of the broadcast shows the state of the hidden bit. Nested service is reached by acknowledging a second, higher-class vector before the first is retired. This checks that an EOI retires only the top one and that the priority falls back to the lower class.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int unsigned IPT_VEC_W   = 8;
    localparam int unsigned IPT_CLASS_W = 4;
    localparam int unsigned IPT_WORD_W  = 32;
    localparam int unsigned IPT_MIN_VEC = 16;

    typedef logic [IPT_VEC_W-1:0] ipt_vec_t;
endpackage

// File: rtl/ipt_msb_find.sv
module ipt_msb_find #(
    parameter int unsigned WIDTH  = 256,
    parameter int unsigned WORD_W = 32
) (
    input  logic [WIDTH-1:0]         bits_i,
    output logic                     found_o,
    output logic [$clog2(WIDTH)-1:0] index_o
);
    localparam int unsigned NWORDS = WIDTH / WORD_W;
    localparam int unsigned IDX_W  = $clog2(WIDTH);
    localparam int unsigned BIT_W  = $clog2(WORD_W);
    localparam int unsigned WSEL_W = IDX_W - BIT_W;

    logic [NWORDS-1:0]  word_any;
    logic [BIT_W-1:0]   word_msb [NWORDS];

    // per-word leading-one search; a word is bits [w*WORD_W +: WORD_W]
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_comb begin
            word_any[w] = 1'b0;
            word_msb[w] = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits_i[w*WORD_W + b]) begin
                    word_any[w] = 1'b1;
                    word_msb[w] = BIT_W'(b);
                end
            end
        end
    end

    // highest non-empty word wins
    always_comb begin
        logic [WSEL_W-1:0] wsel;
        logic [BIT_W-1:0]  bsel;
        found_o = 1'b0;
        wsel    = '0;
        bsel    = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (word_any[w]) begin
                found_o = 1'b1;
                wsel    = WSEL_W'(w);
                bsel    = word_msb[w];
            end
        end
        index_o = {wsel, bsel};
    end
endmodule

// File: rtl/ipt_prio_calc.sv
module ipt_prio_calc #(
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned CLASS_W = 4
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             isr_found_i,
    input  logic [VEC_W-1:0] isr_vec_i,
    output logic [VEC_W-1:0] ppr_o
);
    localparam int unsigned SUB_W = VEC_W - CLASS_W;

    logic [VEC_W-1:0]   isr_eff;
    logic [CLASS_W-1:0] tpr_class;
    logic [CLASS_W-1:0] isr_class;

    always_comb begin
        isr_eff   = isr_found_i ? isr_vec_i : '0;
        tpr_class = tpr_i[VEC_W-1 -: CLASS_W];
        isr_class = isr_eff[VEC_W-1 -: CLASS_W];
        if (tpr_class >= isr_class) begin
            ppr_o = tpr_i;
        end else begin
            ppr_o = {isr_class, {SUB_W{1'b0}}};
        end
    end
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker
    import irq_prio_pkg::*;
#(
    parameter int unsigned VEC_W   = IPT_VEC_W,
    parameter int unsigned CLASS_W = IPT_CLASS_W,
    parameter int unsigned WORD_W  = IPT_WORD_W,
    parameter int unsigned MIN_VEC = IPT_MIN_VEC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en,
    input  logic             sw_en,
    input  logic             acc_valid,
    input  logic [VEC_W-1:0] acc_vector,
    input  logic             acc_level,
    output logic             acc_ok,
    input  logic             tpr_we,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             ack_valid,
    input  logic             eoi_strobe,
    output logic             pend_valid,
    output logic [VEC_W-1:0] pend_vector,
    output logic [VEC_W-1:0] ppr,
    output logic             eoi_bc_valid,
    output logic [VEC_W-1:0] eoi_bc_vector
);
    localparam int unsigned NUM_VEC = 1 << VEC_W;

    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic [NUM_VEC-1:0] insvc;
        logic [NUM_VEC-1:0] trig;
        logic [VEC_W-1:0]   tpr;
        logic               acc_ok;
        logic               bc_valid;
        logic [VEC_W-1:0]   bc_vec;
    } ipt_state_t;

    ipt_state_t st_q, st_d;

    logic             pend_found;
    logic [VEC_W-1:0] pend_top;
    logic             isr_found;
    logic [VEC_W-1:0] isr_top;
    logic [VEC_W-1:0] ppr_w;
    logic             offer;

    ipt_msb_find #(.WIDTH(NUM_VEC), .WORD_W(WORD_W)) u_pend_find (
        .bits_i  (st_q.pend),
        .found_o (pend_found),
        .index_o (pend_top)
    );

    ipt_msb_find #(.WIDTH(NUM_VEC), .WORD_W(WORD_W)) u_isr_find (
        .bits_i  (st_q.insvc),
        .found_o (isr_found),
        .index_o (isr_top)
    );

    ipt_prio_calc #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_prio (
        .tpr_i       (st_q.tpr),
        .isr_found_i (isr_found),
        .isr_vec_i   (isr_top),
        .ppr_o       (ppr_w)
    );

    assign offer = pend_found &&
                   (pend_top[VEC_W-1 -: CLASS_W] > ppr_w[VEC_W-1 -: CLASS_W]);

    always_comb begin
        st_d          = st_q;
        st_d.acc_ok   = 1'b0;
        st_d.bc_valid = 1'b0;
        st_d.bc_vec   = '0;

        // retire highest in-service vector
        if (eoi_strobe && isr_found) begin
            st_d.insvc[isr_top] = 1'b0;
            if (st_q.trig[isr_top]) begin
                st_d.trig[isr_top] = 1'b0;
                st_d.bc_valid      = 1'b1;
                st_d.bc_vec        = isr_top;
            end
        end

        // move offered vector into service
        if (ack_valid && offer) begin
            st_d.pend[pend_top]  = 1'b0;
            st_d.insvc[pend_top] = 1'b1;
        end

        // accept a delivery, judged on the bitmap before this edge
        if (acc_valid && hw_en && sw_en && (acc_vector >= VEC_W'(MIN_VEC))) begin
            if (!st_q.pend[acc_vector]) begin
                st_d.pend[acc_vector] = 1'b1;
                st_d.trig[acc_vector] = acc_level;
                st_d.acc_ok           = 1'b1;
            end else if (!acc_level) begin
                st_d.trig[acc_vector] = 1'b0;
            end
        end

        if (tpr_we) begin
            st_d.tpr = tpr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_ok        = st_q.acc_ok;
    assign pend_valid    = offer;
    assign pend_vector   = pend_top;
    assign ppr           = ppr_w;
    assign eoi_bc_valid  = st_q.bc_valid;
    assign eoi_bc_vector = st_q.bc_vec;
endmodule

// File: rtl/irq_prio_tracker_chk.sv
module irq_prio_tracker_chk #(
    parameter int unsigned VEC_W   = 8,
    parameter int unsigned MIN_VEC = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hw_en,
    input logic             sw_en,
    input logic             acc_valid,
    input logic [VEC_W-1:0] acc_vector,
    input logic             acc_ok,
    input logic             tpr_we,
    input logic [VEC_W-1:0] tpr_wdata,
    input logic             ack_valid,
    input logic             eoi_strobe,
    input logic             pend_valid,
    input logic [VEC_W-1:0] pend_vector,
    input logic [VEC_W-1:0] ppr,
    input logic             eoi_bc_valid
);
    assert_ok_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |-> $past(acc_valid && hw_en && sw_en));

    assert_ok_vec_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |-> ($past(acc_vector) >= VEC_W'(MIN_VEC)));

    assert_offer_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_vector >= VEC_W'(MIN_VEC)));

    assert_ppr_not_below_tpr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tpr_we) |-> (ppr >= $past(tpr_wdata)));

    assert_ack_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && pend_valid) |=> !(pend_valid && (pend_vector == $past(pend_vector))));

    assert_bcast_after_eoi_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bc_valid |-> $past(eoi_strobe));
endmodule

bind irq_prio_tracker irq_prio_tracker_chk #(.VEC_W(VEC_W), .MIN_VEC(MIN_VEC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_en        (hw_en),
    .sw_en        (sw_en),
    .acc_valid    (acc_valid),
    .acc_vector   (acc_vector),
    .acc_ok       (acc_ok),
    .tpr_we       (tpr_we),
    .tpr_wdata    (tpr_wdata),
    .ack_valid    (ack_valid),
    .eoi_strobe   (eoi_strobe),
    .pend_valid   (pend_valid),
    .pend_vector  (pend_vector),
    .ppr          (ppr),
    .eoi_bc_valid (eoi_bc_valid)
);

// File: tb/irq_prio_tracker_bench.sv
module irq_prio_tracker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b0, sw_en = 1'b0;
    logic       acc_valid = 1'b0, acc_level = 1'b0;
    logic [7:0] acc_vector = '0;
    logic       acc_ok;
    logic       tpr_we = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       ack_valid = 1'b0, eoi_strobe = 1'b0;
    logic       pend_valid;
    logic [7:0] pend_vector, ppr;
    logic       eoi_bc_valid;
    logic [7:0] eoi_bc_vector;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    irq_prio_tracker u_irq_prio_tracker (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
        .acc_valid(acc_valid), .acc_vector(acc_vector), .acc_level(acc_level),
        .acc_ok(acc_ok), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .ack_valid(ack_valid), .eoi_strobe(eoi_strobe),
        .pend_valid(pend_valid), .pend_vector(pend_vector), .ppr(ppr),
        .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vector(eoi_bc_vector)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_accept(input logic [7:0] v, input logic lvl);
        @(negedge clk);
        acc_valid = 1'b1; acc_vector = v; acc_level = lvl;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk); ack_valid = 1'b1;
        @(negedge clk); ack_valid = 1'b0;
    endtask

    task automatic do_eoi();
        @(negedge clk); eoi_strobe = 1'b1;
        @(negedge clk); eoi_strobe = 1'b0;
    endtask

    task automatic do_tpr(input logic [7:0] v);
        @(negedge clk); tpr_we = 1'b1; tpr_wdata = v;
        @(negedge clk); tpr_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ppr", ppr, 8'h00);
        chk("R1 pend_valid", pend_valid, 1'b0);
        chk("R1 acc_ok", acc_ok, 1'b0);
        chk("R1 eoi_bc_valid", eoi_bc_valid, 1'b0);
    endtask

    task automatic t_accept_order();
        do_accept(8'h45, 1'b0);
        chk("R2 acc_ok new", acc_ok, 1'b1);
        chk("R6 offer 45", {pend_valid, pend_vector}, {1'b1, 8'h45});
        do_accept(8'h45, 1'b1);
        chk("R3 dup no ok", acc_ok, 1'b0);
        do_accept(8'h91, 1'b0);
        chk("R6 highest 91", pend_vector, 8'h91);
        do_accept(8'h60, 1'b0);
        chk("R6 still 91", pend_vector, 8'h91);
        do_ack();
        chk("R7 ppr isr class", ppr, 8'h90);
        chk("R6 blocked 60", {pend_valid, pend_vector}, {1'b0, 8'h60});
        do_ack();
        chk("R9 ack ignored ppr", ppr, 8'h90);
        chk("R9 ack ignored vec", pend_vector, 8'h60);
        do_eoi();
        chk("R10 ppr drops", ppr, 8'h00);
        chk("R11 edge no bcast", eoi_bc_valid, 1'b0);
        chk("R6 offer 60", {pend_valid, pend_vector}, {1'b1, 8'h60});
        do_eoi();
        chk("R10 empty eoi ppr", ppr, 8'h00);
        chk("R10 empty eoi offer", {pend_valid, pend_vector}, {1'b1, 8'h60});
    endtask

    task automatic t_tpr();
        do_tpr(8'h75);
        chk("R8 ppr=tpr", ppr, 8'h75);
        chk("R6 masked by tpr", pend_valid, 1'b0);
        do_tpr(8'h5A);
        chk("R8 ppr=5A", ppr, 8'h5A);
        chk("R6 unmasked", {pend_valid, pend_vector}, {1'b1, 8'h60});
        do_ack();
        chk("R7 isr wins", ppr, 8'h60);
        chk("R6 45 blocked", pend_valid, 1'b0);
        do_tpr(8'h7C);
        chk("R7 tpr wins", ppr, 8'h7C);
        do_tpr(8'h00);
        chk("R7 back to isr", ppr, 8'h60);
        do_eoi();
        chk("R10 ppr 0", ppr, 8'h00);
        chk("R11 no bcast", eoi_bc_valid, 1'b0);
        do_ack();
        do_eoi();
        chk("R9 drained", pend_valid, 1'b0);
    endtask

    task automatic t_level();
        do_accept(8'h33, 1'b1);
        do_ack();
        do_eoi();
        chk("R11 bcast", {eoi_bc_valid, eoi_bc_vector}, {1'b1, 8'h33});
        @(negedge clk);
        chk("R11 one cycle", eoi_bc_valid, 1'b0);
        do_accept(8'h52, 1'b1);
        do_accept(8'h52, 1'b1);
        chk("R3 level dup no ok", acc_ok, 1'b0);
        do_ack();
        do_eoi();
        chk("R3 level kept", {eoi_bc_valid, eoi_bc_vector}, {1'b1, 8'h52});
        do_accept(8'h52, 1'b1);
        chk("R2 re-accept ok", acc_ok, 1'b1);
        do_accept(8'h52, 1'b0);
        do_ack();
        do_eoi();
        chk("R3 edge dup clears", eoi_bc_valid, 1'b0);
    endtask

    task automatic t_enable();
        hw_en = 1'b0;
        do_accept(8'h80, 1'b0);
        chk("R4 hw off ok", acc_ok, 1'b0);
        chk("R4 hw off offer", pend_valid, 1'b0);
        hw_en = 1'b1; sw_en = 1'b0;
        do_accept(8'h80, 1'b0);
        chk("R4 sw off ok", acc_ok, 1'b0);
        chk("R4 sw off offer", pend_valid, 1'b0);
        sw_en = 1'b1;
    endtask

    task automatic t_floor();
        do_accept(8'h0F, 1'b0);
        chk("R5 low ok", acc_ok, 1'b0);
        chk("R5 low offer", pend_valid, 1'b0);
        do_accept(8'h10, 1'b0);
        chk("R5 16 ok", acc_ok, 1'b1);
        chk("R5 16 offer", {pend_valid, pend_vector}, {1'b1, 8'h10});
        do_ack();
        do_eoi();
    endtask

    task automatic t_nested();
        do_accept(8'h40, 1'b1);
        do_ack();
        chk("R7 nest1", ppr, 8'h40);
        do_accept(8'hA0, 1'b0);
        chk("R6 preempt offer", {pend_valid, pend_vector}, {1'b1, 8'hA0});
        do_ack();
        chk("R7 nest2", ppr, 8'hA0);
        do_eoi();
        chk("R10 top only", ppr, 8'h40);
        chk("R11 edge top none", eoi_bc_valid, 1'b0);
        do_eoi();
        chk("R10 lower retired", ppr, 8'h00);
        chk("R11 lower level bcast", {eoi_bc_valid, eoi_bc_vector}, {1'b1, 8'h40});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        hw_en = 1'b1; sw_en = 1'b1;
        t_accept_order();
        t_tpr();
        t_level();
        t_enable();
        t_floor();
        t_nested();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule